// File: doc/BRIEF.md
# Host-Device Pair Consistency Checker

This block watches a storage host controller state machine and the device-side state machine it talks to. The two can drift into a combination from which neither makes progress: a deadlock or a livelock. A check can be started by a request pulse, for example before each host step. A free-running idle timer also starts one at a fixed interval. During a check the block freezes both parties for a fixed number of cycles and snapshots the host state, the device state and the device's interrupt-enable flag. It then judges the pair against fixed pairing rules.

When the pair is illegal, the block pulses a device reset and a violation flag. It also bumps a saturating violation counter. When the pair is legal, it simply releases the freeze, and both machines continue from the states they were held in. The data-request status bit is not an input and plays no part in the verdict.

State encodings: host 0 idle, 1 ready-check, 2 wait-for-interrupt, 3 status-poll, 4 transfer, and 5 to 7 undefined. Device 0 idle, 1 filling buffer, 2 signalling interrupt, 3 waiting for the host to drain data, and 4 to 7 undefined.

Top module: `hd_pair_checker`

## Requirements
- R1: When `check_req` is sampled high while no check is running, `host_hold` and `dev_hold` go high in the next cycle. They stay high for HOLD_CYC+2 cycles and then both drop together.
- R2: With no request, a check starts on its own after PERIOD consecutive idle cycles, counted from reset or from the end of the previous check.
- R3: The verdict uses only the inputs present in the last of the HOLD_CYC freeze cycles. Values applied earlier in the freeze or later in it have no effect.
- R4: With host state 0 or 1, the pair is legal only if the device state is 0 or 3, whatever the interrupt-enable flag.
- R5: With host state 2, the pair is legal only if the device state is 1 or 2 and `dev_irq_en` is 1. Device state 3 is illegal.
- R6: With host state 4, the pair is legal only if the device state is 3.
- R7: With host state 3, any defined device state (0 to 3) is legal, with either flag value.
- R8: Any undefined host code (5 to 7) or device code (4 to 7) is a violation.
- R9: On an illegal pair, `violation` and `dev_reset` are high for exactly one cycle, the final frozen cycle. On a legal pair, neither pulses.
- R10: `viol_count` starts at 0 after reset and rises by one with each violation pulse, in the same cycle as the pulse. It holds at 2^CNT_W-1.
- R11: A `check_req` that arrives while a check is running neither lengthens the freeze nor queues another check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_req | input | 1 | Request to start a consistency check |
| host_state | input | 3 | Current host state code |
| dev_state | input | 3 | Current device state code |
| dev_irq_en | input | 1 | Device's view of interrupt enable |
| host_hold | output | 1 | Freeze the host state machine |
| dev_hold | output | 1 | Stop the device state machine |
| dev_reset | output | 1 | One-cycle device reset on a violation |
| violation | output | 1 | One-cycle violation flag |
| viol_count | output | CNT_W | Saturating count of violations |

## Verification
Some timing properties are checked on every cycle:
- a request from idle raises the freeze in the next cycle;
- a violation pulse is one cycle long, falls inside the freeze and is followed by its release;
- the counter moves only with a pulse, by exactly one or not at all at saturation.

Only the directed scenarios can show whether each host/device pairing is judged correctly, including undefined codes and the interrupt-enable dependence. The same holds for the moment of the snapshot, the length of the idle interval before an automatic check, and the handling of requests made during a check.

// File: rtl/hdpc_pkg.sv
package hdpc_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    H_IDLE     = 3'd0,
    H_READY    = 3'd1,
    H_WAIT_IRQ = 3'd2,
    H_POLL     = 3'd3,
    H_XFER     = 3'd4
  } host_st_e;

  typedef enum logic [ST_W-1:0] {
    D_IDLE     = 3'd0,
    D_FILL     = 3'd1,
    D_IRQ_SIG  = 3'd2,
    D_DRQ_WAIT = 3'd3
  } dev_st_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HOLD,
    S_JUDGE,
    S_REPORT
  } seq_e;

  typedef struct packed {
    logic [ST_W-1:0] host;
    logic [ST_W-1:0] dev;
    logic            irq_en;
  } snap_t;

endpackage

// File: rtl/hdpc_trigger.sv
module hdpc_trigger #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic check_req,
  output logic trig
);
  localparam int TW = $clog2(PERIOD) + 1;

  logic [TW-1:0] timer_q;
  logic          expired;

  assign expired = (timer_q == TW'(PERIOD - 1));
  assign trig    = idle && (check_req || expired);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= '0;
    end else if (trig || !idle) begin
      timer_q <= '0;
    end else begin
      timer_q <= timer_q + TW'(1);
    end
  end
endmodule

// File: rtl/hdpc_judge.sv
module hdpc_judge
  import hdpc_pkg::*;
(
  input  snap_t snap,
  output logic  legal
);
  logic dev_defined;
  logic dev_rest;
  logic dev_busy;

  assign dev_defined = (snap.dev <= ST_W'(D_DRQ_WAIT));
  assign dev_rest    = (snap.dev == ST_W'(D_IDLE)) || (snap.dev == ST_W'(D_DRQ_WAIT));
  assign dev_busy    = (snap.dev == ST_W'(D_FILL)) || (snap.dev == ST_W'(D_IRQ_SIG));

  always_comb begin
    case (snap.host)
      ST_W'(H_IDLE),
      ST_W'(H_READY):    legal = dev_rest;
      ST_W'(H_WAIT_IRQ): legal = dev_busy && snap.irq_en;
      ST_W'(H_POLL):     legal = dev_defined;
      ST_W'(H_XFER):     legal = (snap.dev == ST_W'(D_DRQ_WAIT));
      default:           legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/hdpc_seq.sv
module hdpc_seq
  import hdpc_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trig,
  input  snap_t live,
  input  logic  legal,
  output snap_t snap_q,
  output logic  idle,
  output logic  hold,
  output logic  report,
  output logic  bad_now
);
  localparam int CW = $clog2(HOLD_CYC) + 1;

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          bad_q;
  logic          last_hold;

  assign last_hold = (cnt_q == CW'(HOLD_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bad_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (trig) st_q <= S_HOLD;
        end
        S_HOLD: begin
          if (last_hold) begin
            snap_q <= live;
            st_q   <= S_JUDGE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        S_JUDGE: begin
          bad_q <= !legal;
          st_q  <= S_REPORT;
        end
        default: begin
          bad_q <= 1'b0;
          st_q  <= S_IDLE;
        end
      endcase
    end
  end

  assign idle    = (st_q == S_IDLE);
  assign hold    = (st_q != S_IDLE);
  assign report  = (st_q == S_REPORT) && bad_q;
  assign bad_now = (st_q == S_JUDGE) && !legal;
endmodule

// File: rtl/hdpc_satcnt.sv
module hdpc_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + W'(1);
    end
  end
endmodule

// File: rtl/hd_pair_checker.sv
module hd_pair_checker
  import hdpc_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int PERIOD   = 1000,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_req,
  input  logic [2:0]       host_state,
  input  logic [2:0]       dev_state,
  input  logic             dev_irq_en,
  output logic             host_hold,
  output logic             dev_hold,
  output logic             dev_reset,
  output logic             violation,
  output logic [CNT_W-1:0] viol_count
);
  snap_t live;
  snap_t snap_q;
  logic  trig;
  logic  idle;
  logic  hold;
  logic  report;
  logic  bad_now;
  logic  legal;

  assign live = '{host: host_state, dev: dev_state, irq_en: dev_irq_en};

  hdpc_trigger #(.PERIOD(PERIOD)) u_trig (
    .clk(clk), .rst_n(rst_n), .idle(idle), .check_req(check_req), .trig(trig)
  );

  hdpc_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .live(live), .legal(legal),
    .snap_q(snap_q), .idle(idle), .hold(hold), .report(report), .bad_now(bad_now)
  );

  hdpc_judge u_judge (.snap(snap_q), .legal(legal));

  hdpc_satcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bad_now), .count(viol_count)
  );

  assign host_hold = hold;
  assign dev_hold  = hold;
  assign dev_reset = report;
  assign violation = report;
endmodule

// File: rtl/hd_pair_checker_sva.sv
module hd_pair_checker_sva #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             check_req,
  input logic             host_hold,
  input logic             dev_hold,
  input logic             dev_reset,
  input logic             violation,
  input logic [CNT_W-1:0] viol_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_req_freezes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (check_req && !host_hold) |=> (host_hold && dev_hold));

  assert_pulse_in_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (violation || dev_reset) |-> (host_hold && dev_hold));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> !violation);

  assert_release_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> !host_hold);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> ((viol_count == $past(viol_count) + CNT_W'(1)) ||
                   ($past(viol_count) == TOP && viol_count == TOP)));

  assert_count_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !violation |-> $stable(viol_count));
endmodule

bind hd_pair_checker hd_pair_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .check_req(check_req), .host_hold(host_hold),
  .dev_hold(dev_hold), .dev_reset(dev_reset), .violation(violation),
  .viol_count(viol_count)
);

// File: tb/hd_pair_checker_test.sv
module hd_pair_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_CYC   = 3;
  localparam int PERIOD     = 64;
  localparam int CNT_W      = 3;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             check_req = 1'b0;
  logic [2:0]       host_state = 3'd0;
  logic [2:0]       dev_state = 3'd0;
  logic             dev_irq_en = 1'b0;
  logic             host_hold;
  logic             dev_hold;
  logic             dev_reset;
  logic             violation;
  logic [CNT_W-1:0] viol_count;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hd_pair_checker #(.HOLD_CYC(HOLD_CYC), .PERIOD(PERIOD), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .check_req(check_req), .host_state(host_state),
    .dev_state(dev_state), .dev_irq_en(dev_irq_en), .host_hold(host_hold),
    .dev_hold(dev_hold), .dev_reset(dev_reset), .violation(violation),
    .viol_count(viol_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    check_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 0;
  endtask

  // Runs one requested check; final values (h1,d1,i1) are applied just before the snapshot cycle.
  task automatic run_check(input string req, input logic [2:0] h0, input logic [2:0] d0,
                           input logic i0, input logic [2:0] h1, input logic [2:0] d1,
                           input logic i1, input bit exp_bad, input bit keep_req);
    host_state = h0; dev_state = d0; dev_irq_en = i0;
    check_req = 1'b1;
    @(negedge clk);
    if (!keep_req) check_req = 1'b0;
    chk(req, "host_hold after request", int'(host_hold), 1);
    chk(req, "dev_hold after request", int'(dev_hold), 1);
    if (HOLD_CYC == 1) begin host_state = h1; dev_state = d1; dev_irq_en = i1; end
    for (int k = 1; k <= HOLD_CYC + 1; k++) begin
      @(negedge clk);
      if (k == HOLD_CYC - 1) begin host_state = h1; dev_state = d1; dev_irq_en = i1; end
      if (k == HOLD_CYC) begin host_state = 3'd7; dev_state = 3'd7; dev_irq_en = ~i1; end
      if (k <= HOLD_CYC) chk(req, "early violation", int'(violation), 0);
    end
    check_req = 1'b0;
    if (exp_bad && exp_cnt < CNT_MAX) exp_cnt++;
    chk(req, "violation pulse", int'(violation), int'(exp_bad));
    chk(req, "dev_reset pulse", int'(dev_reset), int'(exp_bad));
    chk(req, "hold during report", int'(host_hold), 1);
    chk("R10", "viol_count", int'(viol_count), exp_cnt);
    @(negedge clk);
    chk(req, "host_hold released", int'(host_hold), 0);
    chk(req, "dev_hold released", int'(dev_hold), 0);
    chk(req, "violation cleared", int'(violation), 0);
    host_state = 3'd0; dev_state = 3'd0; dev_irq_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pair(input string req, input logic [2:0] h, input logic [2:0] d,
                      input logic ie, input bit bad);
    run_check(req, h, d, ie, h, d, ie, bad, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "count after reset", int'(viol_count), 0);
    chk("R9", "violation after reset", int'(violation), 0);
    chk("R9", "dev_reset after reset", int'(dev_reset), 0);
    chk("R1", "hold after reset", int'(host_hold), 0);
  endtask

  task automatic t_rules();
    pair("R4", 3'd0, 3'd0, 1'b0, 1'b0);
    pair("R4", 3'd1, 3'd3, 1'b1, 1'b0);
    pair("R4", 3'd0, 3'd3, 1'b1, 1'b0);
    pair("R4", 3'd1, 3'd1, 1'b1, 1'b1);
    pair("R4", 3'd0, 3'd2, 1'b0, 1'b1);
    pair("R5", 3'd2, 3'd1, 1'b1, 1'b0);
    pair("R5", 3'd2, 3'd2, 1'b1, 1'b0);
    pair("R5", 3'd2, 3'd1, 1'b0, 1'b1);
    pair("R5", 3'd2, 3'd3, 1'b1, 1'b1);
    pair("R6", 3'd4, 3'd3, 1'b0, 1'b0);
    pair("R6", 3'd4, 3'd0, 1'b1, 1'b1);
    pair("R7", 3'd3, 3'd0, 1'b0, 1'b0);
    pair("R7", 3'd3, 3'd2, 1'b1, 1'b0);
    pair("R7", 3'd3, 3'd1, 1'b0, 1'b0);
    pair("R8", 3'd5, 3'd0, 1'b0, 1'b1);
    pair("R8", 3'd0, 3'd6, 1'b0, 1'b1);
    pair("R8", 3'd3, 3'd7, 1'b1, 1'b1);
  endtask

  task automatic t_snapshot();
    run_check("R3", 3'd4, 3'd0, 1'b0, 3'd4, 3'd3, 1'b0, 1'b0, 1'b0);
    run_check("R3", 3'd0, 3'd0, 1'b0, 3'd2, 3'd3, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_busy_req();
    run_check("R11", 3'd0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1);
    chk("R11", "no queued check", int'(host_hold), 0);
  endtask

  task automatic t_saturation();
    for (int i = 0; i < 3; i++) pair("R10", 3'd6, 3'd6, 1'b0, 1'b1);
    chk("R10", "count saturated", int'(viol_count), CNT_MAX);
  endtask

  task automatic t_periodic();
    int n;
    do_reset();
    host_state = 3'd0; dev_state = 3'd0;
    n = 0;
    do begin @(negedge clk); n++; end while (!host_hold && n < 4 * PERIOD);
    chk("R2", "idle cycles before auto check", n, PERIOD);
    while (host_hold) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!host_hold && n < 4 * PERIOD);
    chk("R2", "interval after previous check", n, PERIOD);
    while (host_hold) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_rules();
    t_snapshot();
    t_busy_req();
    t_saturation();
    t_periodic();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule